// File: doc/BRIEF.md
# Critical-Word-First Line Fill Sequencer

This block runs the refill of one four-word cache line after a miss. A miss request gives the line address, the offset of the word that missed, and a fill order. The block then issues four single-word memory reads, one at a time, and generates the offset of each read from the chosen order. Every returned word goes out on a line-buffer write port. The word that caused the miss is also raised on a critical-word output, so the processor can restart before the line is complete.

Three orders are supported. The ascending order starts at the missed word, counts upward and wraps past the end of the line. The pair order finishes the aligned two-word half that holds the missed word before it fetches the other half, which keeps a 64-bit memory bank open for two beats in a row. The plain order always fetches words 0 to 3 and is for memories that cannot start in the middle of a line. The order, the offset and the line address are latched when the request is taken. Nothing arriving on the request inputs can change a fill once it has started.

Top module: `line_fill_seq`

## Requirements
- R1: After reset, busy is 0, req_ready is 1, and mem_req_valid, lb_we, crit_valid and fill_done are all 0.
- R2: A request is taken only on a cycle with req_valid and req_ready both high, and req_ready stays low while busy is high. A request held on the inputs during a fill is not taken. Changes to req_line, req_off or req_mode during a fill do not alter that fill's read addresses.
- R3: With req_mode = 0 (ascending wrap), beat k reads offset (s + k) mod 4, where s is the missed offset. For s = 1 this gives 1,2,3,0.
- R4: With req_mode = 1 (pair first), the first read is s and the second is the other word of the aligned pair {0,1} or {2,3} that holds s. The third and fourth reads are the other pair, starting with the word whose bit 0 matches that of s. For s = 1 this gives 1,0,3,2.
- R5: With req_mode = 2 or 3 (plain), the reads are offsets 0,1,2,3 whatever the missed offset.
- R6: mem_req_addr is {line, offset}. A read request stays asserted with an unchanged address until mem_req_ready is seen. A new read is issued only after the response to the previous read has been taken.
- R7: Each response taken (mem_rsp_valid with mem_rsp_ready) produces lb_we high for one cycle in the following cycle. In that cycle lb_idx is the offset of that read and lb_data is the response data.
- R8: crit_valid is high for exactly one cycle per fill, together with the write strobe of the word whose offset equals the missed offset. crit_data carries that word.
- R9: fill_done is high for one cycle, in the cycle after the fourth write strobe. busy is high from the cycle after acceptance through the fill_done cycle, and low in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Miss request present |
| req_line | input | ADDR_W | Line address of the miss |
| req_off | input | OFF_W | Offset of the missed word within the line |
| req_mode | input | 2 | Fill order: 0 ascending wrap, 1 pair first, 2 or 3 plain |
| req_ready | output | 1 | Block can take a request |
| busy | output | 1 | Fill in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | ADDR_W+OFF_W | Word address of the read |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | DATA_W | Read data |
| mem_rsp_ready | output | 1 | Block takes read data |
| lb_we | output | 1 | Line-buffer write strobe |
| lb_idx | output | OFF_W | Line-buffer word index |
| lb_data | output | DATA_W | Line-buffer write data |
| crit_valid | output | 1 | Missed word is on crit_data |
| crit_data | output | DATA_W | Missed word |
| fill_done | output | 1 | One-cycle end-of-fill pulse |

## Verification
A wrong beat counter or a wrong latched offset or mode shows up at once on mem_req_addr at the next read request. The same fault then shows one cycle after the response, as a wrong lb_idx and a critical pulse on the wrong strobe. A sequencer state that skips or repeats a beat changes the number of write strobes. It also moves fill_done off the cycle after the fourth strobe and keeps busy high or drops it early. The bench models the memory with stalls and response latency. It checks every read address, every strobe and every end-of-fill pulse against orders it works out for itself.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  typedef enum logic [1:0] {
    FILL_WRAP    = 2'd0,
    FILL_PAIR    = 2'd1,
    FILL_SEQ     = 2'd2,
    FILL_SEQ_ALT = 2'd3
  } fill_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_DRAIN = 3'd3,
    ST_DONE  = 3'd4
  } fill_state_e;

endpackage

// File: rtl/cwf_rst_sync.sv
module cwf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/cwf_order_gen.sv
module cwf_order_gen
  import cwf_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic [OFF_W-1:0] start_off,
  input  fill_mode_e       mode,
  input  logic [OFF_W-1:0] beat,
  output logic [OFF_W-1:0] word_off
);

  always_comb begin
    case (mode)
      FILL_WRAP: word_off = start_off + beat;
      FILL_PAIR: word_off = start_off ^ beat;
      default:   word_off = beat;
    endcase
  end

endmodule

// File: rtl/cwf_ctrl.sv
module cwf_ctrl
  import cwf_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int OFF_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_line,
  input  logic [OFF_W-1:0]        req_off,
  input  logic [1:0]              req_mode,
  output logic                    req_ready,
  output logic                    busy,
  input  logic [OFF_W-1:0]        word_off,
  output logic [OFF_W-1:0]        beat_q,
  output logic [OFF_W-1:0]        start_q,
  output fill_mode_e              mode_q,
  output logic                    mem_req_valid,
  output logic [ADDR_W+OFF_W-1:0] mem_req_addr,
  input  logic                    mem_req_ready,
  input  logic                    mem_rsp_valid,
  output logic                    mem_rsp_ready,
  output logic                    take,
  output logic                    fill_done
);

  localparam logic [OFF_W-1:0] LAST_BEAT = '1;

  fill_state_e       state_q, state_d;
  logic [OFF_W-1:0]  beat_d;
  logic [ADDR_W-1:0] line_q;
  logic              accept;

  assign req_ready     = (state_q == ST_IDLE);
  assign busy          = (state_q != ST_IDLE);
  assign accept        = req_valid && req_ready;
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_rsp_ready = (state_q == ST_WAIT);
  assign take          = mem_rsp_ready && mem_rsp_valid;
  assign fill_done     = (state_q == ST_DONE);
  assign mem_req_addr  = {line_q, word_off};

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_ISSUE;
          beat_d  = '0;
        end
      end
      ST_ISSUE: begin
        if (mem_req_ready) begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (beat_q == LAST_BEAT) begin
            state_d = ST_DRAIN;
          end else begin
            beat_d  = beat_q + 1'b1;
            state_d = ST_ISSUE;
          end
        end
      end
      ST_DRAIN: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      line_q  <= req_line;
      start_q <= req_off;
      mode_q  <= fill_mode_e'(req_mode);
    end
  end

  // R6: a read waiting for the memory keeps its address
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R2: the latched order and offset do not move during a fill
  p_cfg_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mode_q) && $stable(start_q));

endmodule

// File: rtl/cwf_beat_out.sv
module cwf_beat_out #(
  parameter int OFF_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              take_crit,
  input  logic [OFF_W-1:0]  take_off,
  input  logic [DATA_W-1:0] take_data,
  output logic              lb_we,
  output logic [OFF_W-1:0]  lb_idx,
  output logic [DATA_W-1:0] lb_data,
  output logic              crit_valid,
  output logic [DATA_W-1:0] crit_data
);

  logic we_d, crit_d;

  always_comb begin
    we_d   = take;
    crit_d = take && take_crit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_we      <= 1'b0;
      crit_valid <= 1'b0;
    end else begin
      lb_we      <= we_d;
      crit_valid <= crit_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      lb_idx  <= take_off;
      lb_data <= take_data;
    end
  end

  assign crit_data = lb_data;

endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq
  import cwf_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int OFF_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_line,
  input  logic [OFF_W-1:0]        req_off,
  input  logic [1:0]              req_mode,
  output logic                    req_ready,
  output logic                    busy,
  output logic                    mem_req_valid,
  output logic [ADDR_W+OFF_W-1:0] mem_req_addr,
  input  logic                    mem_req_ready,
  input  logic                    mem_rsp_valid,
  input  logic [DATA_W-1:0]       mem_rsp_data,
  output logic                    mem_rsp_ready,
  output logic                    lb_we,
  output logic [OFF_W-1:0]        lb_idx,
  output logic [DATA_W-1:0]       lb_data,
  output logic                    crit_valid,
  output logic [DATA_W-1:0]       crit_data,
  output logic                    fill_done
);

  logic             rst_n_s;
  logic [OFF_W-1:0] beat_q, start_q, word_off;
  fill_mode_e       mode_q;
  logic             take, take_crit;

  cwf_rst_sync #(.STAGES(2)) u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_s)
  );

  cwf_order_gen #(.OFF_W(OFF_W)) u_order (
    .start_off(start_q),
    .mode     (mode_q),
    .beat     (beat_q),
    .word_off (word_off)
  );

  cwf_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .req_valid    (req_valid),
    .req_line     (req_line),
    .req_off      (req_off),
    .req_mode     (req_mode),
    .req_ready    (req_ready),
    .busy         (busy),
    .word_off     (word_off),
    .beat_q       (beat_q),
    .start_q      (start_q),
    .mode_q       (mode_q),
    .mem_req_valid(mem_req_valid),
    .mem_req_addr (mem_req_addr),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready),
    .take         (take),
    .fill_done    (fill_done)
  );

  assign take_crit = (word_off == start_q);

  cwf_beat_out #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .take      (take),
    .take_crit (take_crit),
    .take_off  (word_off),
    .take_data (mem_rsp_data),
    .lb_we     (lb_we),
    .lb_idx    (lb_idx),
    .lb_data   (lb_data),
    .crit_valid(crit_valid),
    .crit_data (crit_data)
  );

  // R7: every write strobe follows a taken response
  p_wr_after_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    lb_we |-> $past(mem_rsp_valid && mem_rsp_ready));

  // R8: the critical pulse rides on the strobe of the missed word
  p_crit_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    crit_valid |-> lb_we && (lb_idx == start_q));

  // R9: end pulse comes after a strobe, not with one
  p_done_after_wr_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    fill_done |-> $past(lb_we) && !lb_we);

  // R9: one-cycle end pulse, then idle
  p_done_then_idle_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    fill_done |=> !fill_done && !busy);

endmodule

// File: tb/line_fill_seq_tb.sv
module line_fill_seq_tb;

  localparam int AW = 28;
  localparam int OW = 2;
  localparam int DW = 32;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_line = '0;
  logic [OW-1:0] req_off = '0;
  logic [1:0]    req_mode = '0;
  logic          req_ready, busy;
  logic          mem_req_valid;
  logic [AW+OW-1:0] mem_req_addr;
  logic          mem_req_ready = 1'b0;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic          mem_rsp_ready;
  logic          lb_we;
  logic [OW-1:0] lb_idx;
  logic [DW-1:0] lb_data;
  logic          crit_valid;
  logic [DW-1:0] crit_data;
  logic          fill_done;

  always #10 clk = ~clk;

  line_fill_seq #(.ADDR_W(AW), .OFF_W(OW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_line(req_line), .req_off(req_off), .req_mode(req_mode),
    .req_ready(req_ready), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_ready(mem_rsp_ready),
    .lb_we(lb_we), .lb_idx(lb_idx), .lb_data(lb_data),
    .crit_valid(crit_valid), .crit_data(crit_data), .fill_done(fill_done)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int stall = 0;
  int lat = 0;
  string order_tag = "R3";

  logic [AW+OW-1:0] exp_addr_q[$];
  logic [OW-1:0]    exp_idx_q[$];
  logic [DW-1:0]    exp_dat_q[$];
  logic             exp_crit_q[$];
  logic             exp_last_q[$];

  logic          pend = 1'b0;
  int            lat_cnt = 0;
  logic [DW-1:0] pend_data = '0;
  logic          prev_last = 1'b0;
  logic          done_flag = 1'b0;

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mdata(input logic [AW+OW-1:0] a);
    return {2'b01, a} ^ 32'h5A3C_0F96;
  endfunction

  function automatic logic [OW-1:0] exp_off(input int s, input int m, input int k);
    int base, low, other;
    if (m == 0) return OW'((s + k) % 4);
    if (m == 1) begin
      base  = s & 2;
      low   = s - base;
      other = 2 - base;
      case (k)
        0:       return OW'(s);
        1:       return OW'(base + 1 - low);
        2:       return OW'(other + low);
        default: return OW'(other + 1 - low);
      endcase
    end
    return OW'(k);
  endfunction

  // memory model and monitor
  always @(negedge clk) begin
    logic [OW-1:0] ei;
    logic [DW-1:0] ed;
    logic          ec, el;
    logic [AW+OW-1:0] ea;
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    mem_req_ready = (stall == 0) ? 1'b1 : ((cyc % (stall + 1)) == 0);
    if (pend && lat_cnt == 0) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = pend_data;
    end else begin
      mem_rsp_valid = 1'b0;
      if (pend && lat_cnt > 0) lat_cnt--;
    end
    #1;
    if (mem_rsp_valid && mem_rsp_ready) pend = 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      chk(!pend, "R6", "read issued before previous response", 32'(pend), 0);
      if (exp_addr_q.size() == 0) begin
        chk(1'b0, order_tag, "unexpected read address", 32'(mem_req_addr), 0);
      end else begin
        ea = exp_addr_q.pop_front();
        chk(mem_req_addr == ea, order_tag, "read address", 32'(mem_req_addr), 32'(ea));
      end
      pend      = 1'b1;
      lat_cnt   = lat;
      pend_data = mdata(mem_req_addr);
    end
    if (rst_n) begin
      chk(fill_done == prev_last, "R9", "fill_done timing", 32'(fill_done), 32'(prev_last));
      if (fill_done) done_flag = 1'b1;
      prev_last = 1'b0;
      if (lb_we) begin
        if (exp_idx_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected write strobe", 32'(lb_idx), 0);
        end else begin
          ei = exp_idx_q.pop_front();
          ed = exp_dat_q.pop_front();
          ec = exp_crit_q.pop_front();
          el = exp_last_q.pop_front();
          chk(lb_idx == ei, "R7", "lb_idx", 32'(lb_idx), 32'(ei));
          chk(lb_data == ed, "R7", "lb_data", lb_data, ed);
          chk(crit_valid == ec, "R8", "crit_valid", 32'(crit_valid), 32'(ec));
          if (ec) chk(crit_data == ed, "R8", "crit_data", crit_data, ed);
          prev_last = el;
        end
      end else if (crit_valid) begin
        chk(1'b0, "R8", "crit_valid without strobe", 1, 0);
      end
    end
  end

  task automatic do_fill(input logic [AW-1:0] line, input int s, input int m, input bit hold_req);
    logic [OW-1:0] o;
    order_tag = (m == 0) ? "R3" : (m == 1) ? "R4" : "R5";
    while (!req_ready) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      o = exp_off(s, m, k);
      exp_addr_q.push_back({line, o});
      exp_idx_q.push_back(o);
      exp_dat_q.push_back(mdata({line, o}));
      exp_crit_q.push_back(o == OW'(s));
      exp_last_q.push_back(k == 3);
    end
    done_flag = 1'b0;
    req_valid = 1'b1;
    req_line  = line;
    req_off   = OW'(s);
    req_mode  = 2'(m);
    @(negedge clk);
    chk(busy == 1'b1, "R9", "busy after accept", 32'(busy), 1);
    chk(req_ready == 1'b0, "R2", "req_ready while busy", 32'(req_ready), 0);
    req_line = line ^ 28'h1;
    req_off  = OW'(s + 1);
    req_mode = 2'(m + 1);
    if (hold_req) begin
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(req_ready == 1'b0, "R2", "held request refused", 32'(req_ready), 0);
      end
    end
    req_valid = 1'b0;
    while (!done_flag) @(negedge clk);
    chk(busy == 1'b0, "R9", "busy after fill_done", 32'(busy), 0);
    chk(req_ready == 1'b1, "R2", "ready after fill", 32'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy", 32'(busy), 0);
    chk(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 1);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", 32'(mem_req_valid), 0);
    chk(lb_we == 1'b0, "R1", "lb_we", 32'(lb_we), 0);
    chk(crit_valid == 1'b0, "R1", "crit_valid", 32'(crit_valid), 0);
    chk(fill_done == 1'b0, "R1", "fill_done", 32'(fill_done), 0);

    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 4; s++)
        do_fill(28'h0ABC000 + 28'(m * 16 + s), s, m, 1'b0);

    stall = 2;
    lat   = 3;
    do_fill(28'h1234567, 1, 0, 1'b0);
    do_fill(28'h0FEDCBA, 2, 1, 1'b0);
    do_fill(28'h0000001, 3, 2, 1'b0);
    do_fill(28'h7777777, 1, 3, 1'b0);

    stall = 1;
    lat   = 1;
    do_fill(28'h0C0FFEE, 1, 1, 1'b1);
    do_fill(28'h0BADF00, 3, 0, 1'b1);

    repeat (5) @(negedge clk);
    chk(exp_addr_q.size() == 0, "R6", "reads left unissued", 32'(exp_addr_q.size()), 0);
    chk(exp_idx_q.size() == 0, "R7", "strobes left unseen", 32'(exp_idx_q.size()), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule